// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds recently used page mappings for a 32-bit virtual address space with 4 KB pages. Each of its entries pairs a 20-bit virtual page number (the tag) with a complete 25-bit page table entry. A lookup presents a virtual address and an access kind. The page number is compared against every tag at once, and the registered answer appears on the next clock edge. On a hit the block returns the entry and the physical address, which is the frame number joined to the unchanged page offset. On a miss it signals the miss so that an outside agent can fetch the entry and load it.

Loading an entry picks a slot with a not-recently-used scheme that is driven by one use bit per slot. A page can also be removed by its page number, or the whole array can be emptied when the address space changes. A permitted hit records the access in the stored entry: it always sets the reference bit, and a write also sets the modify bit. An access that the entry's protection field does not allow is reported as a fault, and the entry is left unchanged.

The page table entry layout, from bit 24 down to bit 0, is: modify (24), reference (23), valid (22), protection (21:20), frame number (19:0).

Top module: `tlb_fa`

## Requirements
- R1: A lookup request (`lk_req`) sampled at a clock edge produces, on that edge, `rsp_valid`=1 together with exactly one of `rsp_hit` or `rsp_miss`. When no lookup is sampled, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_fault` are all 0.
- R2: A lookup hits only when a present slot holds a tag equal to `lk_vaddr[31:12]` and that slot's stored entry has the valid bit (bit 22) set. Otherwise it misses, and `rsp_pte` and `rsp_paddr` are 0.
- R3: On a permitted hit, `rsp_paddr` equals {frame bits 19:0, `lk_vaddr[11:0]`}. For example, 0xBAADF00D with frame 0x900DF gives 0x900DF00D.
- R4: The protection field takes these values: 00 allows nothing, 01 allows read, 10 allows read and write, 11 allows read and execute. The access kinds are `lk_kind` 00 read, 01 write, 10 execute, and 11 is never allowed. A hit whose kind is not allowed sets `rsp_hit` and `rsp_fault`, returns the stored entry unchanged with `rsp_paddr`=0, and does not update the slot.
- R5: A permitted hit sets the reference bit of the stored entry. A permitted write also sets its modify bit. `rsp_pte` shows the entry after this update, and later lookups see the updated bits.
- R6: A fill (`fill_req`) writes `fill_vpn`/`fill_pte` into the array. If the page is already present, the fill overwrites that slot instead of taking a new one.
- R7: A fill of a new page takes the lowest-numbered empty slot. If no slot is empty, it takes the lowest-numbered slot whose use bit is clear. If every use bit is set, all use bits are cleared and slot 0 is taken. A fill and a permitted hit each set the use bit of their slot.
- R8: An invalidate (`inv_req`) empties the slot holding `inv_vpn`, if any. Later lookups of that page miss, other pages are unaffected, and the emptied slot is the first choice for a later fill.
- R9: A flush (`flush_req`) empties every slot, so every later lookup misses until the pages are filled again.
- R10: A lookup whose page is being filled, whose page is being invalidated, or that coincides with a flush reports a miss and updates nothing. A fill that arrives in the same cycle as an invalidate or a flush is dropped. A fill that collides with a lookup of its page completes.
- R11: After reset every slot is empty and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| fill_req | input | 1 | Load one mapping |
| fill_vpn | input | 20 | Page number of the mapping being loaded |
| fill_pte | input | 25 | Page table entry being loaded |
| inv_req | input | 1 | Remove one page |
| inv_vpn | input | 20 | Page number to remove |
| flush_req | input | 1 | Remove all pages |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup found a usable mapping |
| rsp_miss | output | 1 | Lookup found no usable mapping |
| rsp_fault | output | 1 | Hit whose access kind the protection field refuses |
| rsp_pte | output | 25 | Entry returned on a hit |
| rsp_paddr | output | 32 | Physical address on a permitted hit, else 0 |

## Verification
The properties assume that the request inputs are known values that change only between clock edges. The offset and modify checks relate each response to the request sampled one edge earlier, so they assume that the request is held across that edge. The bench drives every input on the falling edge and holds it through the following rising edge, which satisfies this. The stimulus issues one operation per cycle, except in directed collision cases where it pairs operations on purpose. It draws its pages from a pool only slightly larger than the array, so that hits, evictions, use-bit wrap-around and faults all occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PROT_W = 2;
    localparam int PTE_W  = 3 + PROT_W + PFN_W;
    localparam int PA_W   = PFN_W + OFF_W;

    typedef enum logic [1:0] {
        PR_NONE = 2'b00,
        PR_RO   = 2'b01,
        PR_RW   = 2'b10,
        PR_RX   = 2'b11
    } prot_e;

    typedef enum logic [1:0] {
        AC_READ  = 2'b00,
        AC_WRITE = 2'b01,
        AC_EXEC  = 2'b10,
        AC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic             m;
        logic             r;
        logic             v;
        prot_e            prot;
        logic [PFN_W-1:0] pfn;
    } pte_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N  = 32,
    parameter int TW = 20,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [TW-1:0] tags [N],
    input  logic [N-1:0]  present,
    input  logic [TW-1:0] key,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] match;

    // one comparator per slot, all in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = present[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end

    assign any = |match;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  present,
    input  logic [N-1:0]  used,
    output logic [IW-1:0] idx,
    output logic          wrap
);
    logic [IW-1:0] empty_idx;
    logic [IW-1:0] cold_idx;

    // lowest-numbered empty slot and lowest-numbered cold slot
    always_comb begin
        empty_idx = '0;
        cold_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!present[i]) empty_idx = IW'(i);
            if (!used[i])    cold_idx  = IW'(i);
        end
    end

    always_comb begin
        wrap = 1'b0;
        if (!(&present))   idx = empty_idx;
        else if (!(&used)) idx = cold_idx;
        else begin
            idx  = '0;
            wrap = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  prot_e prot,
    input  acc_e  kind,
    output logic  allow
);
    always_comb begin
        unique case (prot)
            PR_NONE: allow = 1'b0;
            PR_RO:   allow = (kind == AC_READ);
            PR_RW:   allow = (kind == AC_READ) || (kind == AC_WRITE);
            PR_RX:   allow = (kind == AC_READ) || (kind == AC_EXEC);
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int N_ENT = 32,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int N_CAM = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_kind,
    input  logic             fill_req,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic             inv_req,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_req,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PTE_W-1:0] rsp_pte,
    output logic [PA_W-1:0]  rsp_paddr
);
    // slot storage
    logic [VPN_W-1:0] tag_q [N_ENT];
    pte_t             pte_q [N_ENT];
    logic [N_ENT-1:0] vld_q, use_q;
    logic [N_ENT-1:0] vld_d, use_d;

    // three parallel searches: lookup, fill, invalidate
    logic [VPN_W-1:0] key   [N_CAM];
    logic             found [N_CAM];
    logic [IW-1:0]    where [N_CAM];

    logic [VPN_W-1:0] lk_vpn;
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign key[0] = lk_vpn;
    assign key[1] = fill_vpn;
    assign key[2] = inv_vpn;

    for (genvar c = 0; c < N_CAM; c++) begin : g_cam
        tlb_cam #(.N(N_ENT), .TW(VPN_W)) u_cam (
            .tags    (tag_q),
            .present (vld_q),
            .key     (key[c]),
            .any     (found[c]),
            .idx     (where[c])
        );
    end

    // replacement choice
    logic [IW-1:0] vic_idx;
    logic          vic_wrap;
    tlb_victim #(.N(N_ENT)) u_vic (
        .present (vld_q),
        .used    (use_q),
        .idx     (vic_idx),
        .wrap    (vic_wrap)
    );

    // lookup decision
    pte_t  sel_pte, upd_pte;
    acc_e  kind;
    logic  allow, fill_go, collide, hit, ok, clear_use;
    logic [IW-1:0] fill_idx;

    assign kind    = acc_e'(lk_kind);
    assign sel_pte = pte_q[where[0]];

    tlb_perm u_perm (
        .prot  (sel_pte.prot),
        .kind  (kind),
        .allow (allow)
    );

    assign fill_go  = fill_req && !inv_req && !flush_req;
    assign collide  = flush_req
                   || (inv_req && (inv_vpn == lk_vpn))
                   || (fill_go && (fill_vpn == lk_vpn));
    assign hit      = lk_req && !collide && found[0] && sel_pte.v;
    assign ok       = hit && allow;
    assign fill_idx = found[1] ? where[1] : vic_idx;
    assign clear_use = fill_go && !found[1] && vic_wrap;

    always_comb begin
        upd_pte   = sel_pte;
        upd_pte.r = 1'b1;
        if (kind == AC_WRITE) upd_pte.m = 1'b1;
    end

    // next presence and use bits; later statements take priority
    always_comb begin
        vld_d = vld_q;
        use_d = use_q;
        if (clear_use) use_d = '0;
        if (ok) use_d[where[0]] = 1'b1;
        if (fill_go) begin
            vld_d[fill_idx] = 1'b1;
            use_d[fill_idx] = 1'b1;
        end
        if (inv_req && found[2]) begin
            vld_d[where[2]] = 1'b0;
            use_d[where[2]] = 1'b0;
        end
        if (flush_req) begin
            vld_d = '0;
            use_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            use_q <= '0;
        end else begin
            vld_q <= vld_d;
            use_q <= use_d;
        end
    end

    // tag and entry storage: a fill wins over a hit update of the same slot
    always_ff @(posedge clk) begin
        if (ok) pte_q[where[0]] <= upd_pte;
        if (fill_go) begin
            tag_q[fill_idx] <= fill_vpn;
            pte_q[fill_idx] <= pte_t'(fill_pte);
        end
    end

    // registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pte   <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= hit;
            rsp_miss  <= lk_req && !hit;
            rsp_fault <= hit && !allow;
            rsp_pte   <= ok ? upd_pte : (hit ? sel_pte : '0);
            rsp_paddr <= ok ? {sel_pte.pfn, lk_vaddr[OFF_W-1:0]} : '0;
        end
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic [1:0]       lk_kind,
    input logic             fill_req,
    input logic [VPN_W-1:0] fill_vpn,
    input logic             inv_req,
    input logic [VPN_W-1:0] inv_vpn,
    input logic             flush_req,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic [PTE_W-1:0] rsp_pte,
    input logic [PA_W-1:0]  rsp_paddr
);
    p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault));

    p_hit_needs_v_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_pte[22]);

    p_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_fault) |-> (rsp_paddr[PA_W-1:OFF_W] == rsp_pte[PFN_W-1:0]));

    p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req ##1 (rsp_hit && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    p_fault_noaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && (rsp_paddr == '0)));

    p_none_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && (rsp_pte[21:20] == 2'b00)) |-> rsp_fault);

    p_ref_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_fault) |-> rsp_pte[23]);

    p_mod_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && (lk_kind == 2'b01)) ##1 (rsp_hit && !rsp_fault) |-> rsp_pte[24]);

    p_after_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req ##1 lk_req |=> rsp_miss);

    p_flush_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && lk_req) |=> rsp_miss);

    p_inv_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && lk_req && (inv_vpn == lk_vaddr[VA_W-1:OFF_W])) |=> rsp_miss);

    p_fill_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && lk_req && (fill_vpn == lk_vaddr[VA_W-1:OFF_W])) |=> rsp_miss);
endmodule

bind tlb_fa tlb_fa_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_vaddr  (lk_vaddr),
    .lk_kind   (lk_kind),
    .fill_req  (fill_req),
    .fill_vpn  (fill_vpn),
    .inv_req   (inv_req),
    .inv_vpn   (inv_vpn),
    .flush_req (flush_req),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pte   (rsp_pte),
    .rsp_paddr (rsp_paddr)
);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
    localparam int NE = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req, fill_req, inv_req, flush_req;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_kind;
    logic [19:0] fill_vpn, inv_vpn;
    logic [24:0] fill_pte;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [24:0] rsp_pte;
    logic [31:0] rsp_paddr;

    always #10 clk = ~clk;

    tlb_fa #(.N_ENT(NE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .inv_req(inv_req), .inv_vpn(inv_vpn), .flush_req(flush_req),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_pte(rsp_pte), .rsp_paddr(rsp_paddr)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // reference state built from the requirements
    bit          m_vld [NE];
    bit          m_use [NE];
    logic [19:0] m_tag [NE];
    logic [24:0] m_pte [NE];

    function automatic logic [24:0] mk(bit v, logic [1:0] pr, logic [19:0] pfn);
        return {1'b0, 1'b0, v, pr, pfn};
    endfunction

    function automatic int mfind(logic [19:0] vpn);
        for (int i = 0; i < NE; i++) if (m_vld[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    // R4 encoding
    function automatic bit mallow(logic [1:0] pr, logic [1:0] k);
        case (pr)
            2'b01:   return k == 2'b00;
            2'b10:   return (k == 2'b00) || (k == 2'b01);
            2'b11:   return (k == 2'b00) || (k == 2'b10);
            default: return 1'b0;
        endcase
    endfunction

    // R7 choice
    function automatic int mvictim(output bit wrap);
        wrap = 1'b0;
        for (int i = 0; i < NE; i++) if (!m_vld[i]) return i;
        for (int i = 0; i < NE; i++) if (!m_use[i]) return i;
        wrap = 1'b1;
        return 0;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        lk_req = 0; lk_vaddr = '0; lk_kind = '0;
        fill_req = 0; fill_vpn = '0; fill_pte = '0;
        inv_req = 0; inv_vpn = '0; flush_req = 0;
    endtask

    // one cycle: drive at falling edge, predict, check at next falling edge
    task automatic op(bit lk, logic [31:0] va, logic [1:0] k,
                      bit fv, logic [19:0] fvpn, logic [24:0] fpte,
                      bit iv, logic [19:0] ivpn, bit fs, string req);
        logic [19:0] vpn;
        bit fgo, coll, hit, al, wrap;
        int li, fi, ii, vi, tgt;
        logic [24:0] up, epte;
        logic [31:0] epa;
        lk_req = lk; lk_vaddr = va; lk_kind = k;
        fill_req = fv; fill_vpn = fvpn; fill_pte = fpte;
        inv_req = iv; inv_vpn = ivpn; flush_req = fs;

        vpn  = va[31:12];
        fgo  = fv && !iv && !fs;
        coll = fs || (iv && ivpn == vpn) || (fgo && fvpn == vpn);
        li   = mfind(vpn);
        fi   = mfind(fvpn);
        ii   = mfind(ivpn);
        vi   = mvictim(wrap);
        hit  = lk && !coll && (li >= 0) && m_pte[li][22];
        al   = hit && mallow(m_pte[li][21:20], k);
        up   = '0; epte = '0; epa = '0;
        if (hit) begin
            up = m_pte[li] | 25'h0800000 | ((k == 2'b01) ? 25'h1000000 : 25'h0);
            epte = al ? up : m_pte[li];
            epa  = al ? {m_pte[li][19:0], va[11:0]} : '0;
        end
        if (fgo && fi < 0 && wrap) for (int i = 0; i < NE; i++) m_use[i] = 0;
        if (al) begin m_pte[li] = up; m_use[li] = 1; end
        if (fgo) begin
            tgt = (fi >= 0) ? fi : vi;
            m_vld[tgt] = 1; m_use[tgt] = 1; m_tag[tgt] = fvpn; m_pte[tgt] = fpte;
        end
        if (iv && ii >= 0) begin m_vld[ii] = 0; m_use[ii] = 0; end
        if (fs) for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_use[i] = 0; end

        @(negedge clk);
        check(req, {3'b0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pte, rsp_paddr},
                   {3'b0, lk, hit, lk && !hit, hit && !al, epte, epa});
        clear_inputs();
    endtask

    task automatic lk_op(logic [31:0] va, logic [1:0] k, string req);
        op(1, va, k, 0, '0, '0, 0, '0, 0, req);
    endtask
    task automatic fill_op(logic [19:0] vpn, logic [24:0] pte, string req);
        op(0, '0, 0, 1, vpn, pte, 0, '0, 0, req);
    endtask
    task automatic inv_op(logic [19:0] vpn, string req);
        op(0, '0, 0, 0, '0, '0, 1, vpn, 0, req);
    endtask
    task automatic flush_op(string req);
        op(0, '0, 0, 0, '0, '0, 0, '0, 1, req);
    endtask

    function automatic logic [19:0] pool(int n);
        return 20'h10000 + 20'(n) * 20'h111;
    endfunction

    initial begin
        clear_inputs();
        rst_n = 0;
        for (int i = 0; i < NE; i++) begin
            m_vld[i] = 0; m_use[i] = 0; m_tag[i] = '0; m_pte[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset outputs", {39'b0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pte[19:0]}, 64'h0);
        rst_n = 1;
        @(negedge clk);
        lk_op(32'h12345678, 2'b00, "R11 empty after reset");
        op(0, '0, 0, 0, '0, '0, 0, '0, 0, "R1 idle gives no response");

        // R3 / R5 translation and bit updates
        fill_op(20'hBAADF, mk(1, 2'b10, 20'h900DF), "R6 fill");
        lk_op(32'hBAADF00D, 2'b00, "R3 read translation, R5 reference bit");
        lk_op(32'hBAADF123, 2'b01, "R5 write sets modify");
        lk_op(32'hBAADFFFF, 2'b00, "R5 modify persists");

        // R2 entry with valid bit clear
        fill_op(20'h00011, mk(0, 2'b10, 20'h00AAA), "R2 fill invalid pte");
        lk_op(32'h00011004, 2'b00, "R2 invalid pte misses");

        // R4 protection cases
        fill_op(20'h00100, mk(1, 2'b00, 20'h00001), "R4 fill");
        fill_op(20'h00101, mk(1, 2'b01, 20'h00002), "R4 fill");
        fill_op(20'h00102, mk(1, 2'b11, 20'h00003), "R4 fill");
        lk_op(32'h00100000, 2'b00, "R4 no-access read faults");
        lk_op(32'h00101000, 2'b01, "R4 read-only write faults");
        lk_op(32'h00101abc, 2'b00, "R4 read-only read allowed");
        lk_op(32'h00102abc, 2'b10, "R4 exec allowed");
        lk_op(32'h00102abc, 2'b01, "R4 exec page write faults");
        lk_op(32'hBAADF000, 2'b10, "R4 read/write page exec faults");
        lk_op(32'hBAADF000, 2'b11, "R4 reserved kind faults");

        // R6 overwrite existing page
        fill_op(20'hBAADF, mk(1, 2'b10, 20'h12345), "R6 refill same page");
        lk_op(32'hBAADF00D, 2'b00, "R6 new frame used");

        // R8 invalidate one
        inv_op(20'hBAADF, "R8 invalidate");
        lk_op(32'hBAADF00D, 2'b00, "R8 invalidated page misses");
        lk_op(32'h00101000, 2'b00, "R8 other page still hits");

        // R10 same-cycle collisions
        op(1, 32'h00200555, 0, 1, 20'h00200, mk(1, 2'b01, 20'h0BEEF), 0, '0, 0, "R10 fill+lookup same page misses");
        lk_op(32'h00200555, 2'b00, "R10 colliding fill completed");
        op(1, 32'h00200555, 0, 0, '0, '0, 1, 20'h00200, 0, "R10 inv+lookup same page misses");
        op(0, '0, 0, 1, 20'h00300, mk(1, 2'b10, 20'h00777), 1, 20'h00999, 0, "R10 fill with inv dropped");
        lk_op(32'h00300000, 2'b00, "R10 dropped fill absent");
        op(1, 32'h00101000, 0, 0, '0, '0, 0, '0, 1, "R10 flush+lookup misses");

        // R9 flush
        fill_op(20'h00400, mk(1, 2'b10, 20'h00444), "R9 fill");
        flush_op("R9 flush");
        lk_op(32'h00400000, 2'b00, "R9 flushed page misses");
        lk_op(32'h00102000, 2'b00, "R9 flushed page misses");

        // R7 replacement order
        for (int i = 0; i < NE; i++) fill_op(pool(i), mk(1, 2'b10, 20'(i + 1)), "R7 fill all");
        fill_op(pool(40), mk(1, 2'b10, 20'h0ABCD), "R7 wrap evicts slot 0");
        lk_op({pool(0), 12'h0}, 2'b00, "R7 slot 0 evicted");
        lk_op({pool(1), 12'h0}, 2'b00, "R7 slot 1 kept, use set");
        fill_op(pool(41), mk(1, 2'b10, 20'h0DCBA), "R7 first cold slot");
        lk_op({pool(2), 12'h0}, 2'b00, "R7 slot 2 evicted");
        lk_op({pool(3), 12'h0}, 2'b00, "R7 slot 3 kept");
        inv_op(pool(10), "R8 free a slot");
        fill_op(pool(42), mk(1, 2'b01, 20'h01111), "R8 empty slot reused");
        lk_op({pool(4), 12'h0}, 2'b00, "R8 slot 4 not evicted");
        lk_op({pool(42), 12'h5}, 2'b00, "R8 refilled page hits");

        // random mix: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 6000; n++) begin
            int sel;
            logic [19:0] v;
            sel = $urandom_range(99);
            v = pool($urandom_range(39));
            if (sel < 55)
                lk_op({v, 12'($urandom)}, 2'($urandom_range(3)), "R1/R2/R3/R4/R5 random lookup");
            else if (sel < 85)
                fill_op(v, {2'($urandom), ($urandom_range(7) != 0), 2'($urandom), 20'($urandom)},
                        "R6/R7 random fill");
            else if (sel < 97)
                inv_op(v, "R8 random invalidate");
            else
                flush_op("R9 random flush");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule